// File: doc/BRIEF.md
# Interrupt Active-State Set Register Bank

This block holds the active state of a group of private peripheral interrupts for one per-core interrupt redistributor. The state is exposed as a bank of 32-bit memory-mapped registers. Software marks interrupts active by writing ones into the set window. A parallel clear window removes active state in the same way. A read of either window returns the current active state.

Every write-one is filtered bit by bit before it reaches the state. A bit is reachable only when all of the following hold:
- the extended range is present;
- the interrupt is implemented;
- affinity routing is enabled for the interrupt's security state;
- the access is allowed to touch the interrupt's security group.

A bit that is not reachable reads as zero and ignores writes. A per-interrupt hardware deactivate input clears active state without any bus traffic.

The bus side is a simple single-cycle slave: byte address, write strobe, write data and a non-secure flag. Read data is registered and appears one cycle after the address is presented. A write in that same cycle is already included in the returned data, so a completed readback always reflects a completed update.

Top module: `pi_active_set_bank`

## Requirements
- R1: After reset every active bit is 0, and a read of any register returns 0.
- R2: A write to the set window, at byte offset 0x300 + 4*n, sets active bit 32*n + x for every reachable bit x written as 1. Bits written as 0, and bits that are already active, keep their value.
- R3: A write to the clear window, at byte offset 0x380 + 4*n, clears active bit 32*n + x for every reachable bit x written as 1. Bits written as 0 keep their value.
- R4: When the security-disable input is 0, a non-secure access reads 0 for every interrupt whose group input marks it secure (group bit = 1), and its writes leave those bits unchanged. When security-disable is 1, non-secure accesses reach secure interrupts.
- R5: An interrupt whose implemented input is 0 reads as 0, and writes from either window leave it unchanged.
- R6: A secure interrupt is reachable only while the secure affinity-routing enable is 1. A non-secure interrupt is reachable only while the non-secure enable is 1. An unreachable bit reads as 0 and ignores writes.
- R7: When the parameter EXT_IMPL is 0, every register reads as 0 and no write changes any active bit.
- R8: A hardware deactivate pulse on bit i clears active bit i at the next clock edge. If a set-window write sets the same bit in the same cycle, the bit ends active.
- R9: An access outside the two windows, to register index n >= NUM_REGS, or with a byte address that is not word-aligned, reads 0 and changes no active bit.
- R10: Read data appears on the cycle after the address is presented. It shows the selected register after any write in that same cycle has been applied, masked by the reachability of the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; a 1 requests set or clear |
| bus_ns | input | 1 | 1 marks the access as non-secure |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| cfg_sec_dis | input | 1 | 1 merges the security states |
| cfg_route_s | input | 1 | Affinity routing enabled for secure interrupts |
| cfg_route_ns | input | 1 | Affinity routing enabled for non-secure interrupts |
| cfg_grp_secure | input | 32*NUM_REGS | Per interrupt: 1 = secure group |
| cfg_impl | input | 32*NUM_REGS | Per interrupt: 1 = implemented |
| hw_deact | input | 32*NUM_REGS | Per-interrupt hardware deactivate pulse |
| active_o | output | 32*NUM_REGS | Current active state of every interrupt |

## Verification
The main instance is built with NUM_REGS = 2 and ADDR_W = 12. This gives 64 interrupts, which is small enough for the bench to hold a bit-exact model and sweep all 16 combinations of access security, security-disable and the two routing enables against one fixed pattern of secure, non-secure and unimplemented interrupts. A second instance with EXT_IMPL = 0 shares the same bus stimulus, so the absent-range behaviour is observed under identical traffic. Registers past the implemented count, misaligned addresses and a same-cycle hardware deactivate racing a software set can all be reached in a few cycles with these sizes.

// File: rtl/pi_act_pkg.sv
// Shared constants and types for the interrupt active-state register bank.
// Assumes a byte-addressed bus whose registers are 32 bits wide.
package pi_act_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned WIN_BYTES = 128;
    localparam int unsigned SET_BASE  = 32'h300;
    localparam int unsigned CLR_BASE  = 32'h380;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;
endpackage

// File: rtl/pi_act_decode.sv
// Address decoder: picks the set or clear window and one-hot selects a
// register inside it. Assumes ADDR_W >= 10 and NUM_REGS <= 32.
// Misaligned or out-of-range addresses select nothing.
module pi_act_decode
    import pi_act_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output win_e                win,
    output logic [NUM_REGS-1:0] reg_sel
);
    localparam int unsigned HI_W = ADDR_W - 7;
    localparam logic [HI_W-1:0] SET_HI = HI_W'(SET_BASE / WIN_BYTES);
    localparam logic [HI_W-1:0] CLR_HI = HI_W'(CLR_BASE / WIN_BYTES);

    logic [HI_W-1:0] hi;
    logic [4:0]      idx;
    logic            aligned;

    assign hi      = addr[ADDR_W-1:7];
    assign idx     = addr[6:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Window selection from the upper address bits.
    always_comb begin
        win = WIN_NONE;
        if (aligned && hi == SET_HI)      win = WIN_SET;
        else if (aligned && hi == CLR_HI) win = WIN_CLR;
    end

    // One select line per implemented register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign reg_sel[r] = (win != WIN_NONE) && (idx == 5'(r));
    end
endmodule

// File: rtl/pi_act_filter.sv
// Per-interrupt reachability filter. A bit is reachable when the range
// exists, the interrupt is implemented, routing is enabled for its
// security state, and the access may touch its group.
// Assumes all configuration inputs are stable during an access.
module pi_act_filter #(
    parameter int unsigned NUM_INT  = 64,
    parameter bit          EXT_IMPL = 1'b1
) (
    input  logic               acc_ns,
    input  logic               sec_dis,
    input  logic               route_s,
    input  logic               route_ns,
    input  logic [NUM_INT-1:0] grp_secure,
    input  logic [NUM_INT-1:0] impl,
    output logic [NUM_INT-1:0] acc_ok
);
    logic ext_on;
    logic ns_blocked;

    assign ext_on     = EXT_IMPL;
    assign ns_blocked = acc_ns & ~sec_dis;

    // One filter term per interrupt.
    for (genvar i = 0; i < NUM_INT; i++) begin : g_bit
        logic routed;
        assign routed    = grp_secure[i] ? route_s : route_ns;
        assign acc_ok[i] = ext_on & impl[i] & routed
                           & ~(ns_blocked & grp_secure[i]);
    end
endmodule

// File: rtl/pi_act_state.sv
// Active-state storage. Set strobes win over clears in the same cycle.
// Assumes the strobes are already filtered by the caller.
module pi_act_state #(
    parameter int unsigned NUM_INT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] set_eff,
    input  logic [NUM_INT-1:0] clr_eff,
    input  logic [NUM_INT-1:0] hw_deact,
    output logic [NUM_INT-1:0] active,
    output logic [NUM_INT-1:0] act_next
);
    // Next state: clear sources first, then set on top.
    always_comb begin
        act_next = (active & ~(clr_eff | hw_deact)) | set_eff;
    end

    // Hold the active bits, zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= '0;
        else        active <= act_next;
    end
endmodule

// File: rtl/pi_active_set_bank.sv
// Top of the interrupt active-state register bank. Builds filtered per-bit
// set and clear strobes from the bus and returns registered read data that
// already includes a same-cycle write. Assumes single-cycle bus accesses.
module pi_active_set_bank
    import pi_act_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned NUM_REGS = 2,
    parameter bit          EXT_IMPL = 1'b1,
    localparam int unsigned NUM_INT = NUM_REGS * REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               bus_ns,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               cfg_sec_dis,
    input  logic               cfg_route_s,
    input  logic               cfg_route_ns,
    input  logic [NUM_INT-1:0] cfg_grp_secure,
    input  logic [NUM_INT-1:0] cfg_impl,
    input  logic [NUM_INT-1:0] hw_deact,
    output logic [NUM_INT-1:0] active_o
);
    win_e               win;
    logic [NUM_REGS-1:0] reg_sel;
    logic [NUM_INT-1:0] acc_ok;
    logic [NUM_INT-1:0] set_eff;
    logic [NUM_INT-1:0] clr_eff;
    logic [NUM_INT-1:0] act_next;
    logic [REG_W-1:0]   rd_word;
    logic [REG_W-1:0]   rdata_q;
    logic               wr_set;
    logic               wr_clr;

    pi_act_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .addr    (bus_addr),
        .win     (win),
        .reg_sel (reg_sel)
    );

    pi_act_filter #(.NUM_INT(NUM_INT), .EXT_IMPL(EXT_IMPL)) u_filter (
        .acc_ns     (bus_ns),
        .sec_dis    (cfg_sec_dis),
        .route_s    (cfg_route_s),
        .route_ns   (cfg_route_ns),
        .grp_secure (cfg_grp_secure),
        .impl       (cfg_impl),
        .acc_ok     (acc_ok)
    );

    assign wr_set = bus_wr && (win == WIN_SET);
    assign wr_clr = bus_wr && (win == WIN_CLR);

    // Per-register expansion of the write strobe into filtered bit strobes.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        assign set_eff[r*REG_W +: REG_W] = {REG_W{wr_set & reg_sel[r]}}
                                           & bus_wdata & acc_ok[r*REG_W +: REG_W];
        assign clr_eff[r*REG_W +: REG_W] = {REG_W{wr_clr & reg_sel[r]}}
                                           & bus_wdata & acc_ok[r*REG_W +: REG_W];
    end

    pi_act_state #(.NUM_INT(NUM_INT)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_eff  (set_eff),
        .clr_eff  (clr_eff),
        .hw_deact (hw_deact),
        .active   (active_o),
        .act_next (act_next)
    );

    // Read mux over the post-update state, masked by reachability.
    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (reg_sel[r]) rd_word |= act_next[r*REG_W +: REG_W] & acc_ok[r*REG_W +: REG_W];
        end
    end

    // Register the read data for return on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/pi_act_chk.sv
// Property checker for the active-state bank, bound into the top module.
// Assumes it sees the filtered strobes next to the stored state.
module pi_act_chk #(
    parameter int unsigned NUM_INT  = 64,
    parameter bit          EXT_IMPL = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_ns,
    input logic               cfg_sec_dis,
    input logic               cfg_route_s,
    input logic               cfg_route_ns,
    input logic [NUM_INT-1:0] cfg_grp_secure,
    input logic [NUM_INT-1:0] cfg_impl,
    input logic [NUM_INT-1:0] hw_deact,
    input logic [NUM_INT-1:0] set_eff,
    input logic [NUM_INT-1:0] clr_eff,
    input logic [NUM_INT-1:0] active_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> active_o == '0);

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_eff != '0) |=> ((active_o & $past(set_eff)) == $past(set_eff)));

    // R3
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eff != '0) |=> ((active_o & $past(clr_eff & ~set_eff)) == '0));

    // R4
    ns_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ns && !cfg_sec_dis) |-> (((set_eff | clr_eff) & cfg_grp_secure) == '0));

    // R5
    unimpl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_eff | clr_eff) & ~cfg_impl) == '0);

    // R6
    route_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_route_s |-> (((set_eff | clr_eff) & cfg_grp_secure) == '0));

    // R6
    route_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_route_ns |-> (((set_eff | clr_eff) & ~cfg_grp_secure) == '0));

    // R7
    absent_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (EXT_IMPL == 1'b0) |-> (active_o == '0));

    // R8
    deact_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_deact != '0) |=> ((active_o & $past(hw_deact & ~set_eff)) == '0));

    // R9
    no_stray_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((active_o & ~$past(active_o) & ~$past(set_eff)) == '0));

    // R9
    no_stray_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~active_o & $past(active_o) & ~$past(clr_eff | hw_deact)) == '0));
endmodule

bind pi_active_set_bank pi_act_chk #(.NUM_INT(NUM_INT), .EXT_IMPL(EXT_IMPL)) u_chk (.*);

// File: tb/pi_active_set_bank_tb.sv
module pi_active_set_bank_tb;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned NUM_REGS = 2;
    localparam int unsigned NI       = NUM_REGS * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic            ns = 1'b0;
    logic            sd = 1'b1;
    logic            rs = 1'b1;
    logic            rn = 1'b1;
    logic [NI-1:0]   grp = 64'h0F0F_00FF_3333_5555;
    logic [NI-1:0]   impl = 64'hFF0F_FFFF_FFFF_FF7F;
    logic [NI-1:0]   deact = '0;
    logic [31:0]     rdata, rdata_off;
    logic [NI-1:0]   act, act_off;
    logic [NI-1:0]   model = '0;
    int              n_cmp = 0;
    int              n_bad = 0;
    bit              done = 1'b0;

    always #2.5 clk = ~clk;

    pi_active_set_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .EXT_IMPL(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_ns(ns), .bus_rdata(rdata), .cfg_sec_dis(sd), .cfg_route_s(rs),
        .cfg_route_ns(rn), .cfg_grp_secure(grp), .cfg_impl(impl),
        .hw_deact(deact), .active_o(act));

    pi_active_set_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .EXT_IMPL(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_ns(ns), .bus_rdata(rdata_off), .cfg_sec_dis(sd), .cfg_route_s(rs),
        .cfg_route_ns(rn), .cfg_grp_secure(grp), .cfg_impl(impl),
        .hw_deact(deact), .active_o(act_off));

    function automatic logic [NI-1:0] reach();
        logic [NI-1:0] m;
        for (int i = 0; i < NI; i++) begin
            m[i] = impl[i] && (grp[i] ? rs : rn) && !(ns && !sd && grp[i]);
        end
        return m;
    endfunction

    // Window kind: 1 set, 2 clear, 0 none; idx gives register number.
    function automatic int win_of(input logic [ADDR_W-1:0] a, output int idx);
        int w;
        w   = 0;
        idx = int'(a[6:2]);
        if (a[1:0] == 2'b00 && idx < NUM_REGS) begin
            if (a[ADDR_W-1:7] == 5'h06) w = 1;
            else if (a[ADDR_W-1:7] == 5'h07) w = 2;
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
        int idx;
        logic [NI-1:0] v;
        if (win_of(a, idx) == 0) return 32'h0;
        v = model & reach();
        return v[idx*32 +: 32];
    endfunction

    task automatic chk(input logic [NI-1:0] got, input logic [NI-1:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        int idx, w;
        logic [NI-1:0] m;
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        w = win_of(a, idx);
        m = reach();
        if (w == 1) model[idx*32 +: 32] = model[idx*32 +: 32] | (d & m[idx*32 +: 32]);
        if (w == 2) model[idx*32 +: 32] = model[idx*32 +: 32] & ~(d & m[idx*32 +: 32]);
        @(negedge clk);
        wr = 1'b0;
        chk({32'h0, rdata}, {32'h0, exp_read(a)}, {tag, " R10 readback"});
        chk(act, model, {tag, " state"});
        chk(act_off, '0, "R7 state");
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        addr = a; wr = 1'b0;
        @(negedge clk);
        chk({32'h0, rdata}, {32'h0, exp_read(a)}, tag);
        chk({32'h0, rdata_off}, '0, "R7 read");
    endtask

    task automatic pulse_deact(input logic [NI-1:0] v);
        @(negedge clk);
        deact = v;
        model = model & ~v;
        @(negedge clk);
        deact = '0;
        chk(act, model, "R8 deactivate");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(act, '0, "R1 state in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(act, '0, "R1 state after reset");
        bus_read(12'h300, "R1 read set0");
        bus_read(12'h384, "R1 read clr1");

        // Near-exhaustive sweep of security and routing controls (R2 R3 R4 R5 R6)
        for (int c = 0; c < 16; c++) begin
            pulse_deact('1);
            @(negedge clk);
            ns = c[0]; sd = c[1]; rs = c[2]; rn = c[3];
            bus_write(12'h300, 32'hFFFF_FFFF, "R2/R4/R5/R6 set0");
            bus_write(12'h300, 32'hFFFF_FFFF, "R2 set0 again");
            bus_write(12'h304, 32'h5A5A_F00F ^ {8{4'(c)}}, "R2/R4/R5/R6 set1");
            bus_write(12'h304, 32'h0, "R2 zero write");
            bus_read(12'h300, "R2 read set0");
            bus_read(12'h384, "R2 read via clr1");
            // Full access view shows what the filtered writes left behind.
            @(negedge clk);
            ns = 1'b0; sd = 1'b1; rs = 1'b1; rn = 1'b1;
            bus_read(12'h304, "R4/R6 full view1");
            @(negedge clk);
            ns = c[0]; sd = c[1]; rs = c[2]; rn = c[3];
            bus_write(12'h380, 32'h0000_FFFF, "R3/R4/R5/R6 clr0");
            bus_write(12'h384, 32'h0, "R3 zero clear");
            bus_write(12'h384, 32'hFFFF_FFFF, "R3 clr1");
            bus_read(12'h300, "R3 read set0");
        end

        @(negedge clk);
        ns = 1'b0; sd = 1'b1; rs = 1'b1; rn = 1'b1;
        pulse_deact('1);

        // R8: deactivate alone, then racing a set of the same bit
        bus_write(12'h300, 32'h0000_0028, "R8 setup");
        pulse_deact(64'h0000_0000_0000_0008);
        bus_write(12'h300, 32'h0000_0008, "R8 re-set");
        @(negedge clk);
        addr = 12'h300; wdata = 32'h0000_0008; wr = 1'b1;
        deact = 64'h0000_0000_0000_0028;
        model = (model & ~64'h28) | 64'h8;
        @(negedge clk);
        wr = 1'b0; deact = '0;
        chk(act, model, "R8 set wins over deactivate");
        chk(model & 64'h28, 64'h8, "R8 expected pattern");

        // R9: out-of-range and misaligned accesses
        bus_write(12'h304, 32'hFFFF_0000, "R9 setup");
        bus_write(12'h308, 32'hFFFF_FFFF, "R9 set beyond count");
        bus_write(12'h388, 32'hFFFF_FFFF, "R9 clear beyond count");
        bus_write(12'h200, 32'hFFFF_FFFF, "R9 outside windows");
        bus_write(12'h302, 32'hFFFF_FFFF, "R9 misaligned set");
        bus_write(12'h381, 32'hFFFF_FFFF, "R9 misaligned clear");
        bus_read(12'h30C, "R9 read beyond count");
        bus_read(12'h304, "R9 state intact");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule